// File: doc/BRIEF.md
# Interrupt Priority Resolver with Polled Acknowledge

This block decides which of its interrupt request lines may interrupt the processor. It holds an in-service register and a mask register. Line 0 has the highest priority and the nesting order is fixed. Requests arrive already latched. The block raises `int_o` whenever a request may be taken. Each change it makes to the in-service register is also given out as a one-hot strobe.

The processor talks to the block through a small register port, made up of chip select, write and read strobes plus a one-bit register select. Select 0 writes and reads the mask. A write with select 1 carries a control word, and a read with select 1 returns the in-service register. The control word can do three things:
- issue a non-specific end-of-interrupt;
- turn the special mask mode on or off;
- arm a poll.

Once a poll is armed, the next read serves as the acknowledge. That read returns the encoded winning level and sets its in-service bit, so no hardware acknowledge cycle is needed.

Top module: `irq_resolver`

## Requirements
- R1: A synchronous reset clears the in-service register, the mask register, the poll flag and special mask mode; afterwards reads of both registers return 0.
- R2: A write with `sel_i`=0 loads the mask from `din_i`. A read with `sel_i`=0 returns the mask, and a read with `sel_i`=1 returns the in-service register, zero-extended to 8 bits. `dout_o` is 0 when no read is in progress.
- R3: In normal mode, the lowest-index set in-service bit blocks that line and every higher-index line. `int_o` is high exactly when some request is unmasked and has a lower index than the blocking line.
- R4: In special mask mode, an in-service bit whose mask bit is set no longer blocks anything. Only unmasked in-service bits block, by the rule of R3.
- R5: A control write (`sel_i`=1) with bit 6 = 1 sets special mask mode to the value of bit 5. With bit 6 = 0, the mode keeps its value.
- R6: A control write with bit 2 = 1 arms a poll. The next read with `cs_i` and `rd_i` high returns a poll word: bit 7 = 1, bits 6..3 = 0, bits 2..0 = index of the winning line. In the same cycle, `isr_set_o` pulses that line's bit, and the bit is set in the in-service register.
- R7: If no request may interrupt during the polled read, the poll word is 0x00 and no in-service bit is set.
- R8: A poll is one-shot. The read that completes it disarms it, and later reads return register contents.
- R9: While a poll is armed, the block uses the requests sampled at the arming write for both `int_o` and the poll word. Changes on `req_i` have no effect until the poll completes.
- R10: A control write with bit 0 = 1 (non-specific end-of-interrupt) clears the lowest-index set in-service bit and pulses that bit on `isr_clr_o`. With the register empty it changes nothing and `isr_clr_o` stays 0.
- R11: When several lines qualify, the lowest index wins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_i | input | NLINES | Latched request lines |
| cs_i | input | 1 | Chip select, active high |
| wr_i | input | 1 | Write strobe, one cycle per access |
| rd_i | input | 1 | Read strobe, one cycle per access |
| sel_i | input | 1 | Register select: 0 mask, 1 control/in-service |
| din_i | input | 8 | Write data |
| dout_o | output | 8 | Read data or poll word |
| int_o | output | 1 | Interrupt request to the processor |
| isr_set_o | output | NLINES | One-hot pulse: in-service bit being set |
| isr_clr_o | output | NLINES | One-hot pulse: in-service bit being cleared |

## Verification
The bench builds the block with the default of eight lines. With eight lines the poll index uses all three code bits, up to 7, and a full-width mask and in-service readback are possible. The scenarios cover a masked in-service line in both modes, a poll with no qualifying request, a poll whose requests change after arming, and an end-of-interrupt on an empty register. A behavioural model predicts `int_o`, `dout_o` and both strobes on every cycle.

// File: rtl/irq_res_pkg.sv
package irq_res_pkg;
  localparam int DATA_W     = 8;
  localparam int CW_EOI     = 0;
  localparam int CW_POLL    = 2;
  localparam int CW_SMM_VAL = 5;
  localparam int CW_SMM_EN  = 6;
  localparam int POLL_FLAG  = 7;

  typedef enum logic {SEL_MASK = 1'b0, SEL_CTRL = 1'b1} port_sel_e;

  typedef struct packed {
    logic smm_en;
    logic smm_val;
    logic poll;
    logic eoi;
  } ctrl_word_t;

  function automatic ctrl_word_t decode_ctrl(input logic [DATA_W-1:0] w);
    ctrl_word_t c;
    c.smm_en  = w[CW_SMM_EN];
    c.smm_val = w[CW_SMM_VAL];
    c.poll    = w[CW_POLL];
    c.eoi     = w[CW_EOI];
    return c;
  endfunction
endpackage

// File: rtl/irq_prio_core.sv
module irq_prio_core #(
  parameter int NLINES = 8,
  parameter int IDXW   = (NLINES > 1) ? $clog2(NLINES) : 1
) (
  input  logic [NLINES-1:0] req,
  input  logic [NLINES-1:0] mask,
  input  logic [NLINES-1:0] isr,
  input  logic              smm,
  output logic [NLINES-1:0] elig,
  output logic [NLINES-1:0] win_oh,
  output logic [IDXW-1:0]   win_idx,
  output logic              any
);
  function automatic logic [NLINES-1:0] lowest_oh(input logic [NLINES-1:0] x);
    return x & (~x + 1'b1);
  endfunction

  // lines strictly ahead of the blocking one; all lines when nothing blocks
  function automatic logic [NLINES-1:0] ahead_of(input logic [NLINES-1:0] oh);
    return (oh == '0) ? '1 : (oh - 1'b1);
  endfunction

  function automatic logic [IDXW-1:0] oh2idx(input logic [NLINES-1:0] oh);
    logic [IDXW-1:0] r;
    r = '0;
    for (int i = 0; i < NLINES; i++)
      if (oh[i]) r = IDXW'(i);
    return r;
  endfunction

  logic [NLINES-1:0] live_isr, blk_oh, open_lines;

  always_comb begin
    live_isr   = smm ? (isr & ~mask) : isr;
    blk_oh     = lowest_oh(live_isr);
    open_lines = ahead_of(blk_oh);
    elig       = req & ~mask & open_lines;
    win_oh     = lowest_oh(elig);
    win_idx    = oh2idx(win_oh);
    any        = |elig;
  end
endmodule

// File: rtl/irq_ctrl_regs.sv
module irq_ctrl_regs
  import irq_res_pkg::*;
#(
  parameter int NLINES = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs,
  input  logic              wr,
  input  logic              rd,
  input  logic              sel,
  input  logic [DATA_W-1:0] din,
  input  logic [NLINES-1:0] req,
  output logic [NLINES-1:0] mask_q,
  output logic              smm_q,
  output logic              poll_q,
  output logic [NLINES-1:0] req_eff,
  output logic              poll_rd,
  output logic              rd_cyc,
  output logic              eoi_wr
);
  logic              wr_cyc, ctrl_wr, mask_wr;
  ctrl_word_t        cw;
  logic [NLINES-1:0] snap_q;

  assign wr_cyc  = cs & wr;
  assign rd_cyc  = cs & rd & ~wr;
  assign ctrl_wr = wr_cyc & (port_sel_e'(sel) == SEL_CTRL);
  assign mask_wr = wr_cyc & (port_sel_e'(sel) == SEL_MASK);
  assign cw      = decode_ctrl(din);
  assign poll_rd = rd_cyc & poll_q;
  assign eoi_wr  = ctrl_wr & cw.eoi;
  assign req_eff = poll_q ? snap_q : req;

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '0;
      smm_q  <= 1'b0;
      poll_q <= 1'b0;
      snap_q <= '0;
    end else begin
      if (mask_wr) mask_q <= din[NLINES-1:0];
      if (ctrl_wr && cw.smm_en) smm_q <= cw.smm_val;
      if (ctrl_wr && cw.poll) begin
        poll_q <= 1'b1;
        snap_q <= req;
      end else if (poll_rd) begin
        poll_q <= 1'b0;
      end
    end
  end

  a_r8_poll_one_shot: assert property (@(posedge clk) disable iff (rst)
    poll_rd |=> !poll_q);
  a_r6_poll_arms: assert property (@(posedge clk) disable iff (rst)
    (ctrl_wr && cw.poll) |=> poll_q);
  a_r5_smm_hold: assert property (@(posedge clk) disable iff (rst)
    !(ctrl_wr && cw.smm_en) |=> $stable(smm_q));
  a_r9_frozen_reqs: assert property (@(posedge clk) disable iff (rst)
    (poll_q && !poll_rd && !(ctrl_wr && cw.poll)) |=> $stable(req_eff));
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (!poll_q && !smm_q && mask_q == '0));
endmodule

// File: rtl/irq_isr_bank.sv
module irq_isr_bank #(
  parameter int NLINES = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NLINES-1:0] set_oh,
  input  logic              eoi,
  output logic [NLINES-1:0] isr_q,
  output logic [NLINES-1:0] clr_oh
);
  function automatic logic [NLINES-1:0] lowest_oh(input logic [NLINES-1:0] x);
    return x & (~x + 1'b1);
  endfunction

  assign clr_oh = eoi ? lowest_oh(isr_q) : '0;

  always_ff @(posedge clk) begin
    if (rst) isr_q <= '0;
    else     isr_q <= (isr_q & ~clr_oh) | set_oh;
  end

  a_r6_set_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0(set_oh));
  a_r6_set_lands: assert property (@(posedge clk) disable iff (rst)
    (set_oh != '0) |=> ((isr_q & $past(set_oh)) == $past(set_oh)));
  a_r10_eoi_drops_one: assert property (@(posedge clk) disable iff (rst)
    (eoi && set_oh == '0 && isr_q != '0) |=>
      ($countones(isr_q) + 1 == $countones($past(isr_q))));
  a_r1_isr_reset: assert property (@(posedge clk)
    rst |=> (isr_q == '0));
endmodule

// File: rtl/irq_resolver.sv
module irq_resolver
  import irq_res_pkg::*;
#(
  parameter int NLINES = 8,
  parameter int IDXW   = (NLINES > 1) ? $clog2(NLINES) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NLINES-1:0] req_i,
  input  logic              cs_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic              sel_i,
  input  logic [DATA_W-1:0] din_i,
  output logic [DATA_W-1:0] dout_o,
  output logic              int_o,
  output logic [NLINES-1:0] isr_set_o,
  output logic [NLINES-1:0] isr_clr_o
);
  logic [NLINES-1:0] mask_q, req_eff, isr_q, elig, win_oh;
  logic [IDXW-1:0]   win_idx;
  logic              smm_q, poll_q, poll_rd, rd_cyc, eoi_wr, any;
  logic [2:0]        win_code;

  irq_ctrl_regs #(.NLINES(NLINES)) u_regs (
    .clk(clk), .rst(rst), .cs(cs_i), .wr(wr_i), .rd(rd_i), .sel(sel_i),
    .din(din_i), .req(req_i), .mask_q(mask_q), .smm_q(smm_q),
    .poll_q(poll_q), .req_eff(req_eff), .poll_rd(poll_rd),
    .rd_cyc(rd_cyc), .eoi_wr(eoi_wr)
  );

  irq_prio_core #(.NLINES(NLINES), .IDXW(IDXW)) u_core (
    .req(req_eff), .mask(mask_q), .isr(isr_q), .smm(smm_q),
    .elig(elig), .win_oh(win_oh), .win_idx(win_idx), .any(any)
  );

  irq_isr_bank #(.NLINES(NLINES)) u_isr (
    .clk(clk), .rst(rst), .set_oh(isr_set_o), .eoi(eoi_wr),
    .isr_q(isr_q), .clr_oh(isr_clr_o)
  );

  assign int_o     = any;
  assign win_code  = 3'(win_idx);
  assign isr_set_o = (poll_rd && any) ? win_oh : '0;

  always_comb begin
    dout_o = '0;
    if (poll_rd) begin
      if (any) begin
        dout_o[POLL_FLAG] = 1'b1;
        dout_o[2:0]       = win_code;
      end
    end else if (rd_cyc) begin
      dout_o = (port_sel_e'(sel_i) == SEL_CTRL) ? DATA_W'(isr_q) : DATA_W'(mask_q);
    end
  end

  a_r7_set_needs_int: assert property (@(posedge clk) disable iff (rst)
    (isr_set_o != '0) |-> int_o);
  a_r6_poll_word_gap: assert property (@(posedge clk) disable iff (rst)
    poll_rd |-> (dout_o[6:3] == 4'b0));
  a_r10_clr_only_on_eoi: assert property (@(posedge clk) disable iff (rst)
    (isr_clr_o != '0) |-> (cs_i && wr_i && sel_i && din_i[CW_EOI]));
endmodule

// File: tb/tb_irq_resolver.sv
`timescale 1ns/1ps
module tb_irq_resolver;
  logic       clk = 1'b0;
  logic       rst;
  logic [7:0] req;
  logic       cs, wr, rd, sel;
  logic [7:0] din;
  logic [7:0] dout, sset, sclr;
  logic       intr;

  int checks = 0;
  int fails  = 0;

  // behavioural model state
  bit [7:0] m_isr, m_mask, m_snap;
  bit       m_smm, m_poll;

  always #2 clk = ~clk;

  irq_resolver dut (
    .clk(clk), .rst(rst), .req_i(req), .cs_i(cs), .wr_i(wr), .rd_i(rd),
    .sel_i(sel), .din_i(din), .dout_o(dout), .int_o(intr),
    .isr_set_o(sset), .isr_clr_o(sclr)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // index of first set bit, 8 if none
  function automatic int first_bit(input bit [7:0] v);
    for (int i = 0; i < 8; i++) if (v[i]) return i;
    return 8;
  endfunction

  task automatic cycle(input bit c, input bit w, input bit r, input bit s,
                       input bit [7:0] d, input string tag);
    bit [7:0] ruse, live, e_dout, e_set, e_clr;
    int blk, win;
    bit e_int;
    cs = c; wr = w; rd = r; sel = s; din = d;
    #1;
    ruse = m_poll ? m_snap : req;
    live = m_smm ? (m_isr & ~m_mask) : m_isr;
    blk  = first_bit(live);
    win  = 8;
    for (int i = 0; i < blk; i++)
      if (ruse[i] && !m_mask[i] && win == 8) win = i;
    e_int  = (win != 8);
    e_dout = 8'h00;
    e_set  = 8'h00;
    e_clr  = 8'h00;
    if (c && r && !w) begin
      if (m_poll) begin
        if (e_int) begin
          e_dout = 8'h80 + 8'(win);
          e_set  = 8'(1 << win);
        end
      end else e_dout = s ? m_isr : m_mask;
    end
    if (c && w && s && d[0] && m_isr != 0) e_clr = 8'(1 << first_bit(m_isr));
    chk(tag, "int_o", intr, e_int);
    chk(tag, "dout_o", dout, e_dout);
    chk(tag, "isr_set_o", sset, e_set);
    chk(tag, "isr_clr_o", sclr, e_clr);
    @(posedge clk);
    m_isr = (m_isr & ~e_clr) | e_set;
    if (c && r && !w && m_poll) m_poll = 0;
    if (c && w && !s) m_mask = d;
    if (c && w && s) begin
      if (d[6]) m_smm = d[5];
      if (d[2]) begin m_poll = 1; m_snap = req; end
    end
    @(negedge clk);
  endtask

  task automatic idle(input string tag);        cycle(0, 0, 0, 0, 8'h00, tag); endtask
  task automatic wmask(input bit [7:0] v, input string tag); cycle(1, 1, 0, 0, v, tag); endtask
  task automatic wctrl(input bit [7:0] v, input string tag); cycle(1, 1, 0, 1, v, tag); endtask
  task automatic rreg(input bit s, input string tag);        cycle(1, 0, 1, s, 8'h00, tag); endtask

  initial begin
    #800000;
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst = 1'b1; req = 8'h00; cs = 0; wr = 0; rd = 0; sel = 0; din = 8'h00;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    m_isr = 0; m_mask = 0; m_snap = 0; m_smm = 0; m_poll = 0;

    // R1: reset state
    rreg(0, "R1 mask after reset");
    rreg(1, "R1 isr after reset");
    idle("R1 idle");

    // R2: mask write and readback
    wmask(8'hF0, "R2 mask write");
    rreg(0, "R2 mask readback");

    // R3: masked lines never interrupt; unmasked one does
    req = 8'h30; idle("R3 masked request");
    req = 8'h08; idle("R3 unmasked request");

    // R6/R11: poll with two qualifying lines, lowest index wins
    req = 8'h0C;
    wctrl(8'h04, "R6 arm poll");
    rreg(1, "R6 R11 poll read");
    rreg(1, "R8 read after poll is isr");

    // R3: in-service line 2 blocks 2 and below, not line 1
    idle("R3 line blocked by own isr");
    req = 8'h0E; idle("R3 higher line passes");
    req = 8'h08; idle("R3 lower line blocked");

    // R4/R5: special mask mode with masked in-service line
    wmask(8'h04, "R4 mask in-service line");
    idle("R4 normal mode still blocked");
    wctrl(8'h60, "R5 enter special mask");
    idle("R4 special mask unblocks lower");
    wctrl(8'h20, "R5 enable bit clear keeps mode");
    idle("R5 mode kept");
    wctrl(8'h40, "R5 leave special mask");
    idle("R5 normal again blocked");

    // R10: end-of-interrupt
    wctrl(8'h01, "R10 eoi clears line 2");
    rreg(1, "R10 isr empty");
    wctrl(8'h01, "R10 eoi on empty");
    rreg(1, "R10 isr still empty");

    // R7: poll with nothing pending
    req = 8'h00;
    wctrl(8'h04, "R7 arm poll");
    rreg(0, "R7 empty poll word");
    rreg(1, "R7 isr untouched");

    // R9: requests frozen between arming and read
    req = 8'h20;
    wctrl(8'h04, "R9 arm poll");
    req = 8'h01;
    idle("R9 frozen int");
    rreg(0, "R9 poll word uses snapshot");
    rreg(1, "R8 R9 isr readback");
    idle("R9 live requests again");

    // R6: highest index code on line 7
    wctrl(8'h01, "R10 eoi line 5");
    wmask(8'h00, "R2 clear mask");
    req = 8'h80;
    wctrl(8'h04, "R6 arm poll line 7");
    rreg(0, "R6 poll word line 7");
    rreg(0, "R8 mask after poll");
    wctrl(8'h01, "R10 eoi line 7");
    idle("R3 final");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule